// File: doc/BRIEF.md
# Carry-Mode ALU with Condition Select

This block is the arithmetic and logic stage of a 32-bit execution datapath. An operation enters as a left operand, a right operand, a field-unit result, a 4-bit operation code and a 4-bit condition selector. The block returns a 32-bit result, the carry value the operation computes for the next step, a one-bit condition flag, and an illegal-code indication. One saved carry bit is kept inside the block. Its use as a carry-in and its update both depend on which of four carry disciplines the operation belongs to.

The condition flag is computed from the adder's borrow-style carry, the sign bits of both operands and the value under test. It covers signed ordering, equality, overflow, borrow, a check on the 3-bit tag at the top of each word, and a fault for results below a kernel address limit. An accepted operation that is marked as rejected, or whose condition flag comes out true, leaves the saved carry unchanged. This lets a trapping or replayed operation be issued again from the same carry state.

Operations arrive on a valid/ready input and leave on a valid/ready output through one register stage. An input is taken when `in_valid` and `in_ready` are both high. `in_ready` is high when the output stage is empty or is being drained in the same cycle. While `out_valid` is high and `out_ready` is low, every output holds its value and no new operation is taken.

Top module: `exec_alu`

## Requirements
- R1: `in_ready` equals `!out_valid || out_ready`. A result appears on the outputs with `out_valid` high in the cycle after acceptance. While `out_valid` is high and `out_ready` is low, all outputs hold.
- R2: Add codes give left + right + cin. Subtract codes give left + ~right + cin. For adds, c32 is the adder carry-out. For subtracts, c32 is the inverted carry-out, which acts as a borrow. Codes: 0 signed add, 1 signed sub, 2 unsigned add, 3 unsigned sub, 4 plain add, 5 plain sub, 6 logical-carry add, 7 logical-carry sub.
- R3: Codes 0 and 2 use the saved carry as cin. Codes 1 and 3 use the inverse of the saved carry. Codes 4 and 6 use cin 0. Codes 5 and 7 use cin 1.
- R4: `out_next_carry` depends on the code. It is 0 for codes 0, 1, 6 and 7. It is c32 for codes 2 and 3. For every other legal code it equals the saved carry.
- R5: On acceptance, the saved carry (`carry_q`) takes `out_next_carry` only when `in_reject` is low and the condition flag is false. In all other cycles it holds. It resets to 0.
- R6: Code 8 passes `in_field` through. Code 9 gives AND, code 10 gives OR and code 11 gives XOR. For these codes c32 is 0.
- R7: Code 12 (bounds check) returns the left operand unchanged. Its conditions are evaluated on left − right, computed with cin 1.
- R8: Let lt = c32 ^ (left[31] ^ right[31]) and z = (test value == 0). The test value is the difference for code 12 and the result otherwise. The selectors are: 0 false, 1 z, 2 lt, 3 lt|z, 5 !z, 6 !lt, 7 !(lt|z).
- R9: Selector 8 gives (c32 ^ test[31]) ^ (left[31] ^ right[31]). Selector 9 gives !c32. Selector 11 gives c32.
- R10: Selector 10 is true when bits [31:29] of the left operand, the right operand or the test value lie strictly between 0 and 7. Selector 12 is its complement.
- R11: Selector 4 is true when the test value is below KERNEL_LIMIT (default 32'h0000_4000). Selector 13 is always true.
- R12: Operation codes 13–15 give result 0, condition false and `out_next_carry` equal to the saved carry. Selector codes 14–15 give condition false. Either kind raises `out_illegal`.
- R13: After reset, `out_valid` is 0, `carry_q` is 0 and `in_ready` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Operation offered |
| in_ready | output | 1 | Operation can be taken |
| in_left | input | 32 | Left operand |
| in_right | input | 32 | Right operand |
| in_field | input | 32 | Field-unit result for pass-through |
| in_op | input | 4 | Operation code |
| in_csel | input | 4 | Condition selector |
| in_reject | input | 1 | Operation rejected; blocks carry commit |
| out_valid | output | 1 | Result present |
| out_ready | input | 1 | Consumer takes result |
| out_result | output | 32 | Result word |
| out_cond | output | 1 | Selected condition |
| out_next_carry | output | 1 | Carry computed for the next step |
| out_illegal | output | 1 | Unused operation or selector code seen |
| carry_q | output | 1 | Saved carry |

## Verification
The assertions assume that inputs are stable from one clock edge to the next, and that `out_ready` may be any value at any time. The carry assertions also assume that a reset is applied before the first operation, so the saved carry starts from a known 0. The stimulus drives every input at the falling edge, so each input holds across the sampling edge. It walks every operation code against every selector code over a spread of operand pairs that cross zero, sign, tag and kernel-limit boundaries. It marks some operations as rejected, so both the commit and the hold paths of the saved carry are exercised in the sweep. A separate phase holds `out_ready` low while a second operation waits.

// File: rtl/exec_alu_pkg.sv
package exec_alu_pkg;

  typedef enum logic [3:0] {
    OP_SADD = 4'd0,  OP_SSUB = 4'd1,  OP_UADD = 4'd2,  OP_USUB = 4'd3,
    OP_VADD = 4'd4,  OP_VSUB = 4'd5,  OP_LADD = 4'd6,  OP_LSUB = 4'd7,
    OP_FLD  = 4'd8,  OP_AND  = 4'd9,  OP_OR   = 4'd10, OP_XOR  = 4'd11,
    OP_BND  = 4'd12
  } alu_op_e;

  localparam logic [3:0] OP_LAST = 4'd12;

  typedef enum logic [3:0] {
    CS_FALSE = 4'd0,  CS_ZERO = 4'd1,  CS_LT   = 4'd2,  CS_LE  = 4'd3,
    CS_ADDR  = 4'd4,  CS_NZ   = 4'd5,  CS_GE   = 4'd6,  CS_GT  = 4'd7,
    CS_OVF   = 4'd8,  CS_NC32 = 4'd9,  CS_TAG  = 4'd10, CS_C32 = 4'd11,
    CS_NTAG  = 4'd12, CS_MODE = 4'd13
  } cond_sel_e;

  localparam logic [3:0] CS_LAST = 4'd13;

  typedef enum logic [1:0] {
    CR_KEEP  = 2'd0,
    CR_CLEAR = 2'd1,
    CR_SAVE  = 2'd2
  } carry_rule_e;

  typedef enum logic [2:0] {
    RS_ZERO  = 3'd0,
    RS_SUM   = 3'd1,
    RS_LEFT  = 3'd2,
    RS_FIELD = 3'd3,
    RS_AND   = 3'd4,
    RS_OR    = 3'd5,
    RS_XOR   = 3'd6
  } res_sel_e;

  typedef struct packed {
    logic        is_adder;
    logic        is_sub;
    logic        use_saved;
    carry_rule_e rule;
    res_sel_e    rsel;
    logic        bad;
  } op_ctl_t;

endpackage

// File: rtl/exec_alu_decode.sv
module exec_alu_decode
  import exec_alu_pkg::*;
(
  input  logic [3:0] op_i,
  input  logic [3:0] csel_i,
  output op_ctl_t    ctl_o,
  output logic       csel_bad_o
);

  always_comb begin
    ctl_o = '{is_adder: 1'b0, is_sub: 1'b0, use_saved: 1'b0,
              rule: CR_KEEP, rsel: RS_ZERO, bad: 1'b0};
    case (op_i)
      OP_SADD: begin ctl_o.is_adder = 1'b1; ctl_o.use_saved = 1'b1;
                     ctl_o.rule = CR_CLEAR; ctl_o.rsel = RS_SUM; end
      OP_SSUB: begin ctl_o.is_adder = 1'b1; ctl_o.use_saved = 1'b1; ctl_o.is_sub = 1'b1;
                     ctl_o.rule = CR_CLEAR; ctl_o.rsel = RS_SUM; end
      OP_UADD: begin ctl_o.is_adder = 1'b1; ctl_o.use_saved = 1'b1;
                     ctl_o.rule = CR_SAVE; ctl_o.rsel = RS_SUM; end
      OP_USUB: begin ctl_o.is_adder = 1'b1; ctl_o.use_saved = 1'b1; ctl_o.is_sub = 1'b1;
                     ctl_o.rule = CR_SAVE; ctl_o.rsel = RS_SUM; end
      OP_VADD: begin ctl_o.is_adder = 1'b1; ctl_o.rsel = RS_SUM; end
      OP_VSUB: begin ctl_o.is_adder = 1'b1; ctl_o.is_sub = 1'b1; ctl_o.rsel = RS_SUM; end
      OP_LADD: begin ctl_o.is_adder = 1'b1; ctl_o.rule = CR_CLEAR; ctl_o.rsel = RS_SUM; end
      OP_LSUB: begin ctl_o.is_adder = 1'b1; ctl_o.is_sub = 1'b1;
                     ctl_o.rule = CR_CLEAR; ctl_o.rsel = RS_SUM; end
      OP_FLD:  ctl_o.rsel = RS_FIELD;
      OP_AND:  ctl_o.rsel = RS_AND;
      OP_OR:   ctl_o.rsel = RS_OR;
      OP_XOR:  ctl_o.rsel = RS_XOR;
      OP_BND:  begin ctl_o.is_adder = 1'b1; ctl_o.is_sub = 1'b1; ctl_o.rsel = RS_LEFT; end
      default: ctl_o.bad = 1'b1;
    endcase
  end

  assign csel_bad_o = (csel_i > CS_LAST);

endmodule

// File: rtl/exec_alu_arith.sv
module exec_alu_arith
  import exec_alu_pkg::*;
#(
  parameter int WIDTH = 32
) (
  input  logic [WIDTH-1:0] left_i,
  input  logic [WIDTH-1:0] right_i,
  input  logic [WIDTH-1:0] field_i,
  input  op_ctl_t          ctl_i,
  input  logic             carry_i,
  output logic [WIDTH-1:0] result_o,
  output logic [WIDTH-1:0] test_o,
  output logic             c32_o,
  output logic             next_carry_o
);

  localparam int SUMW = WIDTH + 1;

  logic [WIDTH-1:0] rhs;
  logic             cin;
  logic [SUMW-1:0]  sum;

  assign rhs = ctl_i.is_sub ? ~right_i : right_i;
  assign cin = ctl_i.use_saved ? (carry_i ^ ctl_i.is_sub) : ctl_i.is_sub;
  assign sum = {1'b0, left_i} + {1'b0, rhs} + {{WIDTH{1'b0}}, cin};

  assign c32_o = ctl_i.is_adder & (sum[WIDTH] ^ ctl_i.is_sub);

  always_comb begin
    case (ctl_i.rsel)
      RS_SUM:   result_o = sum[WIDTH-1:0];
      RS_LEFT:  result_o = left_i;
      RS_FIELD: result_o = field_i;
      RS_AND:   result_o = left_i & right_i;
      RS_OR:    result_o = left_i | right_i;
      RS_XOR:   result_o = left_i ^ right_i;
      default:  result_o = '0;
    endcase
  end

  assign test_o = (ctl_i.rsel == RS_LEFT) ? sum[WIDTH-1:0] : result_o;

  always_comb begin
    case (ctl_i.rule)
      CR_CLEAR: next_carry_o = 1'b0;
      CR_SAVE:  next_carry_o = c32_o;
      default:  next_carry_o = carry_i;
    endcase
  end

endmodule

// File: rtl/exec_alu_cond.sv
module exec_alu_cond
  import exec_alu_pkg::*;
#(
  parameter int               WIDTH        = 32,
  parameter int               TAG_W        = 3,
  parameter logic [WIDTH-1:0] KERNEL_LIMIT = 32'h0000_4000
) (
  input  logic [3:0]       csel_i,
  input  logic [WIDTH-1:0] left_i,
  input  logic [WIDTH-1:0] right_i,
  input  logic [WIDTH-1:0] test_i,
  input  logic             c32_i,
  input  logic             bad_i,
  output logic             cond_o
);

  localparam int               NSRC    = 3;
  localparam logic [TAG_W-1:0] TAG_MAX = '1;

  logic [WIDTH-1:0] src [NSRC];
  logic [NSRC-1:0]  tag_hit;
  logic             sgn_diff, lt, zero, ovf, tag_any;

  assign src[0] = left_i;
  assign src[1] = right_i;
  assign src[2] = test_i;

  for (genvar g = 0; g < NSRC; g++) begin : g_tag
    logic [TAG_W-1:0] tag;
    assign tag        = src[g][WIDTH-1 -: TAG_W];
    assign tag_hit[g] = (tag != '0) && (tag != TAG_MAX);
  end

  assign tag_any  = |tag_hit;
  assign sgn_diff = left_i[WIDTH-1] ^ right_i[WIDTH-1];
  assign lt       = c32_i ^ sgn_diff;
  assign zero     = (test_i == '0);
  assign ovf      = (c32_i ^ test_i[WIDTH-1]) ^ sgn_diff;

  always_comb begin
    cond_o = 1'b0;
    if (!bad_i) begin
      case (csel_i)
        CS_ZERO: cond_o = zero;
        CS_LT:   cond_o = lt;
        CS_LE:   cond_o = lt | zero;
        CS_ADDR: cond_o = (test_i < KERNEL_LIMIT);
        CS_NZ:   cond_o = !zero;
        CS_GE:   cond_o = !lt;
        CS_GT:   cond_o = !(lt | zero);
        CS_OVF:  cond_o = ovf;
        CS_NC32: cond_o = !c32_i;
        CS_TAG:  cond_o = tag_any;
        CS_C32:  cond_o = c32_i;
        CS_NTAG: cond_o = !tag_any;
        CS_MODE: cond_o = 1'b1;
        default: cond_o = 1'b0;
      endcase
    end
  end

endmodule

// File: rtl/exec_alu.sv
module exec_alu
  import exec_alu_pkg::*;
#(
  parameter int                WIDTH        = 32,
  parameter int                TAG_W        = 3,
  parameter logic [WIDTH-1:0]  KERNEL_LIMIT = 32'h0000_4000
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             in_valid,
  output logic             in_ready,
  input  logic [WIDTH-1:0] in_left,
  input  logic [WIDTH-1:0] in_right,
  input  logic [WIDTH-1:0] in_field,
  input  logic [3:0]       in_op,
  input  logic [3:0]       in_csel,
  input  logic             in_reject,
  output logic             out_valid,
  input  logic             out_ready,
  output logic [WIDTH-1:0] out_result,
  output logic             out_cond,
  output logic             out_next_carry,
  output logic             out_illegal,
  output logic             carry_q
);

  op_ctl_t          ctl;
  logic             csel_bad;
  logic [WIDTH-1:0] res_w, test_w;
  logic             c32_w, nc_w, cond_w, acc;

  exec_alu_decode u_dec (
    .op_i       (in_op),
    .csel_i     (in_csel),
    .ctl_o      (ctl),
    .csel_bad_o (csel_bad)
  );

  exec_alu_arith #(.WIDTH(WIDTH)) u_arith (
    .left_i       (in_left),
    .right_i      (in_right),
    .field_i      (in_field),
    .ctl_i        (ctl),
    .carry_i      (carry_q),
    .result_o     (res_w),
    .test_o       (test_w),
    .c32_o        (c32_w),
    .next_carry_o (nc_w)
  );

  exec_alu_cond #(.WIDTH(WIDTH), .TAG_W(TAG_W), .KERNEL_LIMIT(KERNEL_LIMIT)) u_cond (
    .csel_i  (in_csel),
    .left_i  (in_left),
    .right_i (in_right),
    .test_i  (test_w),
    .c32_i   (c32_w),
    .bad_i   (ctl.bad | csel_bad),
    .cond_o  (cond_w)
  );

  assign in_ready = !out_valid || out_ready;
  assign acc      = in_valid && in_ready;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_valid      <= 1'b0;
      out_result     <= '0;
      out_cond       <= 1'b0;
      out_next_carry <= 1'b0;
      out_illegal    <= 1'b0;
      carry_q        <= 1'b0;
    end else begin
      if (acc) begin
        out_valid      <= 1'b1;
        out_result     <= res_w;
        out_cond       <= cond_w;
        out_next_carry <= nc_w;
        out_illegal    <= ctl.bad | csel_bad;
        if (!in_reject && !cond_w) carry_q <= nc_w;
      end else if (out_ready) begin
        out_valid <= 1'b0;
      end
    end
  end

  // R1: a stalled result holds
  p_hold_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_result) && $stable(out_cond)
                                   && $stable(out_next_carry) && $stable(out_illegal)));

  // R5: saved carry moves only on an accepted, unrejected operation
  p_carry_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !(acc && !in_reject) |=> $stable(carry_q));

  // R4: signed add/sub report a cleared carry
  p_signed_clear_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (acc && (in_op == OP_SADD || in_op == OP_SSUB)) |=> !out_next_carry);

  // R7: bounds check returns the left operand
  p_bound_left_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (acc && in_op == OP_BND) |=> (out_result == $past(in_left)));

  // R11: mode-fault selector always fires on a legal operation
  p_mode_true_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (acc && in_csel == CS_MODE && in_op <= OP_LAST) |=> out_cond);

  // R12: an illegal code never raises the condition
  p_illegal_quiet_r12: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && out_illegal) |-> !out_cond);

endmodule

// File: tb/test_exec_alu.sv
module test_exec_alu;

  localparam logic [31:0] KLIM = 32'h0000_4000;
  localparam int NP = 12;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid = 1'b0;
  logic        in_ready;
  logic [31:0] in_left = '0, in_right = '0, in_field = '0;
  logic [3:0]  in_op = '0, in_csel = '0;
  logic        in_reject = 1'b0;
  logic        out_valid;
  logic        out_ready = 1'b1;
  logic [31:0] out_result;
  logic        out_cond, out_next_carry, out_illegal, carry_q;

  int n_chk = 0;
  int n_bad = 0;
  bit done = 0;
  logic model_cy = 1'b0;
  logic [31:0] pa [NP];
  logic [31:0] pb [NP];

  always #4 clk = ~clk;

  exec_alu i_exec_alu (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_left(in_left), .in_right(in_right), .in_field(in_field),
    .in_op(in_op), .in_csel(in_csel), .in_reject(in_reject),
    .out_valid(out_valid), .out_ready(out_ready), .out_result(out_result),
    .out_cond(out_cond), .out_next_carry(out_next_carry),
    .out_illegal(out_illegal), .carry_q(carry_q)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic bit tagin(input logic [31:0] w);
    return (w[31:29] != 3'd0) && (w[31:29] != 3'd7);
  endfunction

  // Expected values straight from the requirement text
  task automatic model(input logic [3:0] op, input logic [3:0] cs,
                       input logic [31:0] a, input logic [31:0] b, input logic [31:0] f,
                       input logic cy, output logic [31:0] res, output logic cnd,
                       output logic nc, output logic ill);
    logic [32:0] s;
    logic [31:0] t;
    logic add, sub, cin, c32, lt, z;
    add = (op <= 4'd7) || (op == 4'd12);
    sub = (op <= 4'd7) ? op[0] : (op == 4'd12);
    case (op)
      4'd0, 4'd2: cin = cy;
      4'd1, 4'd3: cin = ~cy;
      4'd4, 4'd6: cin = 1'b0;
      default:    cin = 1'b1;
    endcase
    s   = sub ? ({1'b0, a} + {1'b0, ~b} + 33'(cin)) : ({1'b0, a} + {1'b0, b} + 33'(cin));
    c32 = add ? (sub ? ~s[32] : s[32]) : 1'b0;
    case (op)
      4'd8:    res = f;
      4'd9:    res = a & b;
      4'd10:   res = a | b;
      4'd11:   res = a ^ b;
      4'd12:   res = a;
      4'd13, 4'd14, 4'd15: res = 32'd0;
      default: res = s[31:0];
    endcase
    t = (op == 4'd12) ? s[31:0] : res;
    case (op)
      4'd0, 4'd1, 4'd6, 4'd7: nc = 1'b0;
      4'd2, 4'd3:             nc = c32;
      default:                nc = cy;
    endcase
    lt = c32 ^ (a[31] ^ b[31]);
    z  = (t == 32'd0);
    case (cs)
      4'd1:  cnd = z;
      4'd2:  cnd = lt;
      4'd3:  cnd = lt | z;
      4'd4:  cnd = (t < KLIM);
      4'd5:  cnd = !z;
      4'd6:  cnd = !lt;
      4'd7:  cnd = !(lt | z);
      4'd8:  cnd = (c32 ^ t[31]) ^ (a[31] ^ b[31]);
      4'd9:  cnd = !c32;
      4'd10: cnd = tagin(a) | tagin(b) | tagin(t);
      4'd11: cnd = c32;
      4'd12: cnd = !(tagin(a) | tagin(b) | tagin(t));
      4'd13: cnd = 1'b1;
      default: cnd = 1'b0;
    endcase
    ill = (op > 4'd12) || (cs > 4'd13);
    if (op > 4'd12) cnd = 1'b0;
  endtask

  function automatic string res_req(input logic [3:0] op);
    if (op > 4'd12) return "R12 result";
    if (op == 4'd12) return "R7 result";
    if (op >= 4'd8) return "R6 result";
    if (op <= 4'd3) return "R3 result";
    return "R2 result";
  endfunction

  function automatic string cond_req(input logic [3:0] op, input logic [3:0] cs);
    if (op > 4'd12 || cs > 4'd13) return "R12 cond";
    if (cs == 4'd8 || cs == 4'd9 || cs == 4'd11) return "R9 cond";
    if (cs == 4'd10 || cs == 4'd12) return "R10 cond";
    if (cs == 4'd4 || cs == 4'd13) return "R11 cond";
    if (op == 4'd12) return "R7 cond";
    return "R8 cond";
  endfunction

  // Drives one operation at a falling edge and checks it one edge later
  task automatic run_op(input logic [3:0] op, input logic [3:0] cs,
                        input logic [31:0] a, input logic [31:0] b, input logic rej);
    logic [31:0] er;
    logic ec, en, ei;
    in_op = op; in_csel = cs; in_left = a; in_right = b;
    in_field = a ^ {b[15:0], b[31:16]}; in_reject = rej; in_valid = 1'b1;
    model(op, cs, a, b, in_field, model_cy, er, ec, en, ei);
    @(posedge clk);
    @(negedge clk);
    if (!rej && !ec) model_cy = en;
    chk("R1 out_valid", 32'(out_valid), 32'd1);
    chk(res_req(op), out_result, er);
    chk(cond_req(op, cs), 32'(out_cond), 32'(ec));
    chk((op > 4'd12) ? "R12 next carry" : "R4 next carry", 32'(out_next_carry), 32'(en));
    chk("R12 illegal flag", 32'(out_illegal), 32'(ei));
    chk("R5 saved carry", 32'(carry_q), 32'(model_cy));
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog expired");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    pa[0] = 32'h0000_0000; pb[0] = 32'h0000_0000;
    pa[1] = 32'h0000_0001; pb[1] = 32'h0000_0001;
    pa[2] = 32'hFFFF_FFFF; pb[2] = 32'h0000_0001;
    pa[3] = 32'h7FFF_FFFF; pb[3] = 32'h0000_0001;
    pa[4] = 32'h8000_0000; pb[4] = 32'h0000_0001;
    pa[5] = 32'h0000_0005; pb[5] = 32'h0000_0007;
    pa[6] = 32'h0000_0007; pb[6] = 32'h0000_0005;
    pa[7] = 32'h0000_3FFF; pb[7] = 32'h0000_0001;
    pa[8] = 32'h2000_0000; pb[8] = 32'hC000_0000;
    pa[9] = 32'hE000_0000; pb[9] = 32'hE000_0000;
    pa[10] = 32'h1234_5678; pb[10] = 32'h9ABC_DEF0;
    pa[11] = 32'h8000_0000; pb[11] = 32'h7FFF_FFFF;

    repeat (3) @(negedge clk);
    // R13: reset state
    chk("R13 out_valid", 32'(out_valid), 32'd0);
    chk("R13 carry_q", 32'(carry_q), 32'd0);
    chk("R13 in_ready", 32'(in_ready), 32'd1);
    rst_n = 1'b1;
    @(negedge clk);

    // R3: a chained unsigned add sees the carry the previous one saved
    run_op(4'd2, 4'd0, 32'hFFFF_FFFF, 32'h0000_0001, 1'b0);
    run_op(4'd2, 4'd0, 32'h0000_0010, 32'h0000_0020, 1'b0);
    chk("R3 chained carry-in", out_result, 32'h0000_0031);

    for (int p = 0; p < NP; p++)
      for (int o = 0; o < 16; o++)
        for (int c = 0; c < 16; c++)
          run_op(o[3:0], c[3:0], pa[p], pb[p], ((p + o + c) % 5) == 0);

    // R1: back-pressure holds the first result and stalls the second
    in_valid = 1'b0;
    @(negedge clk);
    out_ready = 1'b0;
    in_op = 4'd9; in_csel = 4'd0; in_left = 32'hF0F0_1234; in_right = 32'h0FF0_FFFF;
    in_reject = 1'b0; in_valid = 1'b1;
    @(posedge clk); @(negedge clk);
    in_op = 4'd10; in_left = 32'h0000_0F00; in_right = 32'h0000_00F0;
    for (int k = 0; k < 3; k++) begin
      chk("R1 stall in_ready", 32'(in_ready), 32'd0);
      chk("R1 stall hold", out_result, 32'h00F0_1234);
      @(negedge clk);
    end
    out_ready = 1'b1;
    @(posedge clk); @(negedge clk);
    chk("R1 second result", out_result, 32'h0000_0FF0);
    in_valid = 1'b0;
    @(posedge clk); @(negedge clk);
    chk("R1 drained", 32'(out_valid), 32'd0);

    done = 1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

endmodule